// File: doc/BRIEF.md
# Guarded Nonvolatile Byte Memory Controller

This block is the register front end of a small byte-wide nonvolatile data store. A CPU reaches it over a plain register bus: an address register, a data register and a control register. Reading a byte means loading the address and setting the read strobe. The addressed byte then lands in the data register, and the CPU is held for four cycles. Writing a byte takes two steps. Software first sets the master enable, which the hardware drops by itself four cycles later. Software must then set the write strobe while that enable is still up.

An accepted write holds the CPU for two cycles and then runs on its own for `WR_CYCLES` clocks. The write strobe bit stays at one for that whole time, and software polls it to learn when the write is done. A write that has started always finishes and commits its byte, even if reset is asserted in the middle of it. A level ready interrupt is raised whenever no write is running, provided both the local enable and the global interrupt enable are on. The store itself is a behavioural array of `DEPTH` bytes, either 128 or 256.

Top module: `nvm_wr_ctrl`

## Requirements
- R1: After a synchronous active-low reset with no write running, the control register reads 0x00, `cpu_stall` is low and `ready_irq` is low. Register select 0 is address, 1 is data and 2 is control. Control bits are: 3 interrupt enable, 2 master enable, 1 write strobe, 0 read strobe. Bits 7..4 always read zero.
- R2: The address and data registers read back the value last written. Address bits at and above log2(DEPTH) read zero.
- R3: Writing control with bit 2 set makes bit 2 read 1 for the four cycles after that write. It then reads 0 with no further action.
- R4: A control write with bit 1 set starts a write only if bit 2 already reads 1 and no write is running. Otherwise it has no effect: bit 1 reads 0, there is no stall, and the stored byte is unchanged.
- R5: An accepted write holds `cpu_stall` high for exactly the 2 cycles after the strobe edge. An accepted read holds it high for exactly 4.
- R6: After an accepted write, bit 1 reads 1 for exactly `WR_CYCLES` cycles. It then reads 0, and at that point the data register value captured at the start is stored at the captured address.
- R7: An accepted read loads the data register with the byte at the address register in the strobe cycle. Bit 0 reads 0 immediately afterwards.
- R8: A read strobe issued while a write is running is ignored: the data register is unchanged and there is no stall.
- R9: `ready_irq` is high exactly when `irq_global_en` is 1, control bit 3 is 1, and no write is running.
- R10: A reset asserted during a write does not stop it. Bit 1 keeps reading 1 until the write is done, and the byte is committed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_we | input | 1 | Register write strobe from the CPU |
| bus_sel | input | 2 | Register select: 0 address, 1 data, 2 control |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Register read data for the selected register (combinational) |
| irq_global_en | input | 1 | Global interrupt enable from the CPU |
| cpu_stall | output | 1 | Holds the CPU while high |
| ready_irq | output | 1 | Level ready interrupt |

## Verification
A guard counter that is one cycle off shows up within a single cycle. The fourth or fifth cycle after arming either accepts or rejects a strobe, and the bench probes that exact boundary. A wrong write timer is caught at the first clear of the strobe bit, which is sampled on the cycle before and the cycle it is due. A lost commit appears as a wrong readback a few cycles after completion. Stall counters are sampled cycle by cycle. Reset reaching into the array shows up as a missing byte after the mid-write reset.

// File: rtl/nvmc_pkg.sv
// Package: shared register selects and control bit positions for the
// nonvolatile memory controller. Assumes an 8-bit register bus.
package nvmc_pkg;
    typedef enum logic [1:0] {
        SEL_ADDR = 2'd0,
        SEL_DATA = 2'd1,
        SEL_CTRL = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;

    localparam int CB_IRQ_EN = 3;
    localparam int CB_ARM    = 2;
    localparam int CB_WRITE  = 1;
    localparam int CB_READ   = 0;
endpackage

// File: rtl/nvmc_guard.sv
// Module: arming window for writes. A load restarts a window of HOLD
// cycles; armed is high while the window is open. Assumes HOLD >= 1.
module nvmc_guard #(
    parameter int HOLD = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm_load,
    output logic armed
);
    localparam int CW = $clog2(HOLD + 1);
    logic [CW-1:0] win_q;

    // Window counter: reload on arm, otherwise count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            win_q <= '0;
        else if (arm_load)
            win_q <= CW'(HOLD);
        else if (win_q != '0)
            win_q <= win_q - 1'b1;
    end

    assign armed = (win_q != '0);
endmodule

// File: rtl/nvmc_stall.sv
// Module: CPU hold generator. A down-counter loaded with WR_HOLD on a
// write start or RD_HOLD on a read; stall is high while it is nonzero.
// Assumes the two loads never arrive in the same cycle.
module nvmc_stall #(
    parameter int WR_HOLD = 2,
    parameter int RD_HOLD = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_go,
    input  logic rd_go,
    output logic stall
);
    localparam int MAXH = (WR_HOLD > RD_HOLD) ? WR_HOLD : RD_HOLD;
    localparam int CW   = $clog2(MAXH + 1);
    logic [CW-1:0] cnt_q;

    // Hold counter: load on an accepted access, then drain.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (wr_go)
            cnt_q <= CW'(WR_HOLD);
        else if (rd_go)
            cnt_q <= CW'(RD_HOLD);
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign stall = (cnt_q != '0);
endmodule

// File: rtl/nvmc_array.sv
// Module: behavioural byte store with a self-timed write. A start
// captures address and data; the byte commits WR_CYCLES clocks later.
// Has no reset input on purpose: a started write always completes.
// The timer powers up idle through its declaration value.
module nvmc_array #(
    parameter int DEPTH     = 256,
    parameter int WR_CYCLES = 40,
    parameter int AW        = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          wr_start,
    input  logic [AW-1:0] wr_addr,
    input  logic [7:0]    wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [7:0]    rd_data,
    output logic          busy
);
    localparam int TW = $clog2(WR_CYCLES + 1);

    logic [7:0]    store [DEPTH];
    logic [TW-1:0] tmr_q = '0;
    logic [AW-1:0] pend_addr_q;
    logic [7:0]    pend_data_q;

    // Write timer: load on start, count down, commit on the last tick.
    always_ff @(posedge clk) begin
        if (wr_start) begin
            tmr_q       <= TW'(WR_CYCLES);
            pend_addr_q <= wr_addr;
            pend_data_q <= wr_data;
        end else if (tmr_q != '0) begin
            tmr_q <= tmr_q - 1'b1;
            if (tmr_q == TW'(1))
                store[pend_addr_q] <= pend_data_q;
        end
    end

    assign rd_data = store[rd_addr];
    assign busy    = (tmr_q != '0);
endmodule

// File: rtl/nvm_wr_ctrl.sv
// Module: register front end of the nonvolatile byte memory. Holds the
// address, data and control registers, guards writes behind a
// self-clearing arm bit, issues array accesses, stalls the CPU and
// raises the level ready interrupt. Assumes DEPTH is at most 256.
module nvm_wr_ctrl #(
    parameter int DEPTH     = 256,
    parameter int WR_CYCLES = 40,
    parameter int ARM_HOLD  = 4,
    parameter int WR_STALL  = 2,
    parameter int RD_STALL  = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bus_we,
    input  logic [1:0] bus_sel,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    input  logic       irq_global_en,
    output logic       cpu_stall,
    output logic       ready_irq
);
    import nvmc_pkg::*;

    localparam int AW = $clog2(DEPTH);

    logic [AW-1:0] addr_q;
    logic [7:0]    data_q;
    logic          rie_q;
    logic          armed;
    logic          busy;
    logic [7:0]    arr_rd;
    logic          ctrl_we;
    logic          wr_req;
    logic          rd_req;
    logic          wr_go;
    logic          rd_go;
    logic          arm_load;
    logic [7:0]    addr_ext;

    // Decode control-register writes into access requests.
    always_comb begin
        ctrl_we  = rst_n && bus_we && (bus_sel == SEL_CTRL);
        wr_req   = ctrl_we && bus_wdata[CB_WRITE];
        rd_req   = ctrl_we && bus_wdata[CB_READ];
        wr_go    = wr_req && armed && !busy;
        rd_go    = rd_req && !busy && !wr_go;
        arm_load = ctrl_we && bus_wdata[CB_ARM];
    end

    // Address register: no reset value, software must load it.
    always_ff @(posedge clk) begin
        if (rst_n && bus_we && (bus_sel == SEL_ADDR))
            addr_q <= bus_wdata[AW-1:0];
    end

    // Data register: loaded by software or by an accepted read.
    always_ff @(posedge clk) begin
        if (rd_go)
            data_q <= arr_rd;
        else if (rst_n && bus_we && (bus_sel == SEL_DATA))
            data_q <= bus_wdata;
    end

    // Interrupt enable bit of the control register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rie_q <= 1'b0;
        else if (ctrl_we)
            rie_q <= bus_wdata[CB_IRQ_EN];
    end

    nvmc_guard #(.HOLD(ARM_HOLD)) u_guard (
        .clk      (clk),
        .rst_n    (rst_n),
        .arm_load (arm_load),
        .armed    (armed)
    );

    nvmc_stall #(.WR_HOLD(WR_STALL), .RD_HOLD(RD_STALL)) u_stall (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_go (wr_go),
        .rd_go (rd_go),
        .stall (cpu_stall)
    );

    nvmc_array #(.DEPTH(DEPTH), .WR_CYCLES(WR_CYCLES), .AW(AW)) u_array (
        .clk      (clk),
        .wr_start (wr_go),
        .wr_addr  (addr_q),
        .wr_data  (data_q),
        .rd_addr  (addr_q),
        .rd_data  (arr_rd),
        .busy     (busy)
    );

    // Read mux for the selected register.
    always_comb begin
        addr_ext         = '0;
        addr_ext[AW-1:0] = addr_q;
        case (bus_sel)
            SEL_ADDR: bus_rdata = addr_ext;
            SEL_DATA: bus_rdata = data_q;
            SEL_CTRL: bus_rdata = {4'b0000, rie_q, armed, busy, 1'b0};
            default:  bus_rdata = 8'h00;
        endcase
    end

    assign ready_irq = irq_global_en && rie_q && !busy;
endmodule

// File: rtl/nvmc_checker.sv
// Module: protocol checks for nvm_wr_ctrl, bound to every instance.
module nvmc_checker (
    input logic clk,
    input logic rst_n,
    input logic wr_go,
    input logic rd_go,
    input logic rd_req,
    input logic busy,
    input logic armed,
    input logic cpu_stall,
    input logic ready_irq
);
    // R4: a write only starts inside the arming window.
    a_r4_start_needs_arm: assert property (@(posedge clk) disable iff (!rst_n)
        wr_go |-> armed);

    // R5: any accepted access stalls the CPU in the next cycle.
    a_r5_stall_follows_go: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_go || rd_go) |=> cpu_stall);

    // R6: the array only turns busy after an accepted write.
    a_r6_busy_from_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(wr_go));

    // R8: a read during a running write is not accepted.
    a_r8_read_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && busy) |-> !rd_go);

    // R9: no ready interrupt while a write runs.
    a_r9_irq_quiet_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !ready_irq);
endmodule

bind nvm_wr_ctrl nvmc_checker u_nvmc_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_go     (wr_go),
    .rd_go     (rd_go),
    .rd_req    (rd_req),
    .busy      (busy),
    .armed     (armed),
    .cpu_stall (cpu_stall),
    .ready_irq (ready_irq)
);

// File: tb/test_nvm_wr_ctrl.sv
// Directed bench for nvm_wr_ctrl; one task per scenario.
module test_nvm_wr_ctrl;
    localparam int WRC = 20;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_we = 1'b0;
    logic [1:0] bus_sel = 2'd0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       irq_global_en = 1'b0;
    logic       cpu_stall;
    logic       ready_irq;

    int n_run = 0;
    int n_fail = 0;
    int cyc = 0;
    bit done = 1'b0;

    nvm_wr_ctrl #(.DEPTH(256), .WR_CYCLES(WRC)) i_nvm_wr_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .bus_we        (bus_we),
        .bus_sel       (bus_sel),
        .bus_wdata     (bus_wdata),
        .bus_rdata     (bus_rdata),
        .irq_global_en (irq_global_en),
        .cpu_stall     (cpu_stall),
        .ready_irq     (ready_irq)
    );

    always #5 clk = ~clk;

    // Watchdog: an overlong run counts as a failure.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000 && !done) begin
            n_fail = n_fail + 1;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_run = n_run + 1;
        if (act !== exp) begin
            n_fail = n_fail + 1;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Register write: driven at a falling edge, taken at the next rise.
    task automatic reg_wr(input logic [1:0] sel, input logic [7:0] val);
        bus_we = 1'b1; bus_sel = sel; bus_wdata = val;
        @(posedge clk);
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic reg_rd(input logic [1:0] sel, output logic [7:0] val);
        bus_sel = sel;
        #1;
        val = bus_rdata;
    endtask

    task automatic wait_done();
        logic [7:0] c;
        for (int i = 0; i < 200; i++) begin
            reg_rd(2'd2, c);
            if (!c[1]) break;
            @(negedge clk);
        end
    endtask

    task automatic do_write(input logic [7:0] a, input logic [7:0] d);
        reg_wr(2'd0, a);
        reg_wr(2'd1, d);
        reg_wr(2'd2, 8'h04);
        reg_wr(2'd2, 8'h02);
        wait_done();
    endtask

    task automatic do_read(input logic [7:0] a, output logic [7:0] d);
        reg_wr(2'd0, a);
        reg_wr(2'd2, 8'h01);
        reg_rd(2'd1, d);
    endtask

    task automatic t_reset();
        logic [7:0] v;
        reg_rd(2'd2, v);
        chk("R1 ctrl after reset", v, 8'h00);
        chk("R1 stall after reset", {7'd0, cpu_stall}, 8'h00);
        chk("R1 irq after reset", {7'd0, ready_irq}, 8'h00);
    endtask

    task automatic t_regs();
        logic [7:0] v;
        reg_wr(2'd0, 8'h3C);
        reg_rd(2'd0, v);
        chk("R2 address readback", v, 8'h3C);
        reg_wr(2'd1, 8'hA5);
        reg_rd(2'd1, v);
        chk("R2 data readback", v, 8'hA5);
    endtask

    task automatic t_guard();
        logic [7:0] v;
        reg_wr(2'd2, 8'h04);
        reg_rd(2'd2, v);
        chk("R3 arm set", v, 8'h04);
        repeat (3) @(negedge clk);
        reg_rd(2'd2, v);
        chk("R3 arm fourth cycle", v, 8'h04);
        @(negedge clk);
        reg_rd(2'd2, v);
        chk("R3 arm self-cleared", v, 8'h00);
    endtask

    task automatic t_no_arm();
        logic [7:0] v;
        do_write(8'h10, 8'h11);
        reg_wr(2'd1, 8'h99);
        reg_wr(2'd2, 8'h02);
        reg_rd(2'd2, v);
        chk("R4 strobe without arm", v, 8'h00);
        chk("R4 no stall without arm", {7'd0, cpu_stall}, 8'h00);
        @(negedge clk);
        do_read(8'h10, v);
        chk("R4 byte unchanged", v, 8'h11);
    endtask

    task automatic t_late();
        logic [7:0] v;
        reg_wr(2'd0, 8'h10);
        reg_wr(2'd1, 8'h66);
        reg_wr(2'd2, 8'h04);
        repeat (4) @(negedge clk);
        reg_wr(2'd2, 8'h02);
        reg_rd(2'd2, v);
        chk("R4 strobe five cycles late", v, 8'h00);
        chk("R4 no stall when late", {7'd0, cpu_stall}, 8'h00);
        @(negedge clk);
        do_read(8'h10, v);
        chk("R4 byte unchanged after late", v, 8'h11);
    endtask

    task automatic t_timing();
        logic [7:0] v;
        reg_wr(2'd0, 8'h20);
        reg_wr(2'd1, 8'h5E);
        reg_wr(2'd2, 8'h04);
        reg_wr(2'd2, 8'h02);
        chk("R5 write stall cycle 1", {7'd0, cpu_stall}, 8'h01);
        reg_rd(2'd2, v);
        chk("R6 strobe busy", v & 8'h02, 8'h02);
        @(negedge clk);
        chk("R5 write stall cycle 2", {7'd0, cpu_stall}, 8'h01);
        @(negedge clk);
        chk("R5 write stall ended", {7'd0, cpu_stall}, 8'h00);
        repeat (WRC - 3) @(negedge clk);
        reg_rd(2'd2, v);
        chk("R6 strobe last busy cycle", v & 8'h02, 8'h02);
        @(negedge clk);
        reg_rd(2'd2, v);
        chk("R6 strobe cleared", v & 8'h02, 8'h00);
        reg_wr(2'd2, 8'h01);
        chk("R5 read stall cycle 1", {7'd0, cpu_stall}, 8'h01);
        reg_rd(2'd1, v);
        chk("R7 read loads data", v, 8'h5E);
        reg_rd(2'd2, v);
        chk("R7 read strobe clear", v, 8'h00);
        repeat (3) @(negedge clk);
        chk("R5 read stall cycle 4", {7'd0, cpu_stall}, 8'h01);
        @(negedge clk);
        chk("R5 read stall ended", {7'd0, cpu_stall}, 8'h00);
    endtask

    task automatic t_read_busy();
        logic [7:0] v;
        reg_wr(2'd0, 8'h30);
        reg_wr(2'd1, 8'h31);
        reg_wr(2'd2, 8'h04);
        reg_wr(2'd2, 8'h02);
        reg_wr(2'd1, 8'h5A);
        reg_wr(2'd2, 8'h01);
        chk("R8 no stall for blocked read", {7'd0, cpu_stall}, 8'h00);
        reg_rd(2'd1, v);
        chk("R8 data unchanged", v, 8'h5A);
        wait_done();
        do_read(8'h30, v);
        chk("R6 captured data stored", v, 8'h31);
    endtask

    task automatic t_irq();
        irq_global_en = 1'b1;
        reg_wr(2'd2, 8'h08);
        chk("R9 irq idle enabled", {7'd0, ready_irq}, 8'h01);
        irq_global_en = 1'b0;
        #1;
        chk("R9 irq global off", {7'd0, ready_irq}, 8'h00);
        irq_global_en = 1'b1;
        reg_wr(2'd0, 8'h40);
        reg_wr(2'd2, 8'h0C);
        reg_wr(2'd2, 8'h0A);
        chk("R9 irq low while busy", {7'd0, ready_irq}, 8'h00);
        wait_done();
        chk("R9 irq back when done", {7'd0, ready_irq}, 8'h01);
        irq_global_en = 1'b0;
    endtask

    task automatic t_reset_mid();
        logic [7:0] v;
        reg_wr(2'd0, 8'h77);
        reg_wr(2'd1, 8'hC3);
        reg_wr(2'd2, 8'h04);
        reg_wr(2'd2, 8'h02);
        repeat (3) @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        reg_rd(2'd2, v);
        chk("R10 strobe held through reset", v, 8'h02);
        rst_n = 1'b1;
        @(negedge clk);
        wait_done();
        do_read(8'h77, v);
        chk("R10 byte committed after reset", v, 8'hC3);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_regs();
        t_guard();
        t_no_arm();
        t_late();
        t_timing();
        t_read_busy();
        t_irq();
        t_reset_mid();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule